// File: doc/BRIEF.md
# Fetch/Execute Bus Cycle Controller

This block sequences the external bus of a simple processor. It repeatedly fetches an instruction word from the address held in its instruction pointer, gives the fetched word one bus-idle cycle for an outside decoder to inspect, and then, if the decoder asks for it, runs a single execute-phase access: a memory read, memory write, I/O read or I/O write. An execute phase that needs no bus access is skipped, and the next fetch follows at once.

Every bus cycle type is encoded on three control lines: a memory-or-I/O select, a write-or-read direction and a data-or-control phase flag. A ready input stretches any bus cycle by wait states. The data bus is modelled as separate input and output ports with an output enable in place of a tri-state pad. After each completed fetch the instruction pointer either steps by one word or takes a new value from a load input.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busActive` is low. In the second cycle a fetch starts at address 0. Asserting reset during any cycle aborts that cycle and restarts the same way.
- R2: During a fetch, `busActive`=1, `memIoSel`=1, `wrRd`=0, `dataCtl`=0 and `dataOe`=0, and `addrOut` carries the instruction pointer.
- R3: A fetch completes on the first rising edge where `ready` is 1. The word on `rdData` at that edge appears on `instrWord` from the next cycle onward.
- R4: When a fetch completes with `loadIp`=0, the instruction pointer advances by 4, wrapping modulo 2^32. When it completes with `loadIp`=1, the pointer takes `newIp`.
- R5: A completed fetch is followed by exactly one decode cycle with `busActive`=0. At the end of that cycle, `execEn`, `execIo`, `execWr`, `execAddr` and `execWrData` are captured. When `execEn`=0, the next cycle is a fetch.
- R6: A memory read (`execEn`=1, `execIo`=0, `execWr`=0) drives (`memIoSel`,`wrRd`,`dataCtl`)=(1,0,1) with `addrOut`=`execAddr`. The `rdData` value at the completing edge appears on `readWord`.
- R7: A memory write (`execEn`=1, `execIo`=0, `execWr`=1) drives (1,1,1), raises `dataOe` and drives `execWrData` on `dataOut`. `readWord` is left unchanged.
- R8: An I/O read (`execIo`=1, `execWr`=0) drives (0,0,1) and captures `rdData` on `readWord` like R6.
- R9: An I/O write (`execIo`=1, `execWr`=1) drives (0,1,1) with `dataOe` high and `execWrData` on `dataOut`.
- R10: While `busActive` is high and `ready` is low, the cycle is held. `busActive`, the three control lines, `addrOut`, `dataOut` and `dataOe` keep their values into the next cycle.
- R11: `dataOe` is high only during execute-phase write cycles.
- R12: Whenever `busActive` is low, the three control lines, `addrOut`, `dataOut` and `dataOe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| ready | input | 1 | Completes the current bus cycle when high |
| rdData | input | 32 | Data bus input (instruction or read data) |
| loadIp | input | 1 | Replace the pointer at fetch completion |
| newIp | input | 32 | Pointer value used with loadIp |
| execEn | input | 1 | Decoder requests an execute-phase bus access |
| execIo | input | 1 | 1 = I/O access, 0 = memory access |
| execWr | input | 1 | 1 = write, 0 = read |
| execAddr | input | 32 | Execute-phase address |
| execWrData | input | 32 | Execute-phase write data |
| busActive | output | 1 | A bus cycle is in progress |
| memIoSel | output | 1 | 1 = memory, 0 = I/O |
| wrRd | output | 1 | 1 = processor drives data out, 0 = processor reads |
| dataCtl | output | 1 | 1 = execute phase, 0 = fetch phase |
| addrOut | output | 32 | Address bus |
| dataOut | output | 32 | Data bus output value |
| dataOe | output | 1 | Data bus output enable |
| instrWord | output | 32 | Last fetched instruction |
| readWord | output | 32 | Last execute-phase read result |

## Verification
Several properties are checked on every cycle inside the RTL. These cover the fetch encoding, that the output enable appears only on execute writes, that all outputs are zero while the bus is idle, that a cycle held by a low ready keeps its address and control lines, that the decode cycle lasts one cycle, and that the pointer steps by a word. The bench scenarios cover what depends on the data path and on sequences of cycles. These include which word lands on `instrWord` and `readWord`, that a write leaves `readWord` alone, the loaded and wrapped pointer values, that a skipped execute phase goes straight to a fetch, and the restart after a reset in the middle of a cycle.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FETCH  = 2'd1,
    PH_DECODE = 2'd2,
    PH_EXEC   = 2'd3
  } phase_t;

  typedef struct packed {
    phase_t phase;
    logic   grabInstr;
    logic   grabCmd;
    logic   grabRead;
  } strobe_t;

endpackage

// File: rtl/bcc_ctrl.sv
module bcc_ctrl
  import bcc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ready,
  input  logic    execEn,
  output strobe_t stb
);

  phase_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      PH_IDLE:   stateNext = PH_FETCH;
      PH_FETCH:  if (ready) stateNext = PH_DECODE;
      PH_DECODE: stateNext = execEn ? PH_EXEC : PH_FETCH;
      PH_EXEC:   if (ready) stateNext = PH_FETCH;
      default:   stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb.phase     = state;
    stb.grabInstr = (state == PH_FETCH) && ready;
    stb.grabCmd   = (state == PH_DECODE);
    stb.grabRead  = (state == PH_EXEC) && ready;
  end

  // R5
  decode_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_DECODE) |=> (state != PH_DECODE));

  // R1
  idle_to_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE) |=> (state == PH_FETCH));

endmodule

// File: rtl/bcc_datapath.sv
module bcc_datapath
  import bcc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IP_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              ready,
  input  logic [DATA_W-1:0] rdData,
  input  logic              loadIp,
  input  logic [ADDR_W-1:0] newIp,
  input  logic              execIo,
  input  logic              execWr,
  input  logic [ADDR_W-1:0] execAddr,
  input  logic [DATA_W-1:0] execWrData,
  output logic              busActive,
  output logic              memIoSel,
  output logic              wrRd,
  output logic              dataCtl,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] instrWord,
  output logic [DATA_W-1:0] readWord
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(IP_STEP);

  logic [ADDR_W-1:0] ipReg;
  logic [DATA_W-1:0] instrReg, readReg, cmdData;
  logic [ADDR_W-1:0] cmdAddr;
  logic              cmdIo, cmdWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ipReg    <= '0;
      instrReg <= '0;
      readReg  <= '0;
      cmdAddr  <= '0;
      cmdData  <= '0;
      cmdIo    <= 1'b0;
      cmdWr    <= 1'b0;
    end else begin
      if (stb.grabInstr) begin
        instrReg <= rdData;
        ipReg    <= loadIp ? newIp : ipReg + STEP;
      end
      if (stb.grabCmd) begin
        cmdIo   <= execIo;
        cmdWr   <= execWr;
        cmdAddr <= execAddr;
        cmdData <= execWrData;
      end
      if (stb.grabRead && !cmdWr) readReg <= rdData;
    end
  end

  always_comb begin
    busActive = 1'b0;
    memIoSel  = 1'b0;
    wrRd      = 1'b0;
    dataCtl   = 1'b0;
    addrOut   = '0;
    dataOut   = '0;
    dataOe    = 1'b0;
    unique case (stb.phase)
      PH_FETCH: begin
        busActive = 1'b1;
        memIoSel  = 1'b1;
        addrOut   = ipReg;
      end
      PH_EXEC: begin
        busActive = 1'b1;
        memIoSel  = ~cmdIo;
        wrRd      = cmdWr;
        dataCtl   = 1'b1;
        addrOut   = cmdAddr;
        dataOe    = cmdWr;
        dataOut   = cmdWr ? cmdData : '0;
      end
      default: ;
    endcase
  end

  assign instrWord = instrReg;
  assign readWord  = readReg;

  // R2
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && !dataCtl) |-> (memIoSel && !wrRd && !dataOe));

  // R11
  oe_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (busActive && wrRd && dataCtl));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busActive |-> (addrOut == '0 && !memIoSel && !wrRd && !dataCtl && !dataOe));

  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && !ready) |=> (busActive && $stable(addrOut) && $stable(dataOut)
                               && $stable({memIoSel, wrRd, dataCtl, dataOe})));

  // R4
  ip_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.grabInstr && !loadIp) |=> (ipReg == $past(ipReg) + STEP));

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IP_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ready,
  input  logic [DATA_W-1:0] rdData,
  input  logic              loadIp,
  input  logic [ADDR_W-1:0] newIp,
  input  logic              execEn,
  input  logic              execIo,
  input  logic              execWr,
  input  logic [ADDR_W-1:0] execAddr,
  input  logic [DATA_W-1:0] execWrData,
  output logic              busActive,
  output logic              memIoSel,
  output logic              wrRd,
  output logic              dataCtl,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] instrWord,
  output logic [DATA_W-1:0] readWord
);

  strobe_t stb;

  bcc_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .ready  (ready),
    .execEn (execEn),
    .stb    (stb)
  );

  bcc_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IP_STEP (IP_STEP)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .ready      (ready),
    .rdData     (rdData),
    .loadIp     (loadIp),
    .newIp      (newIp),
    .execIo     (execIo),
    .execWr     (execWr),
    .execAddr   (execAddr),
    .execWrData (execWrData),
    .busActive  (busActive),
    .memIoSel   (memIoSel),
    .wrRd       (wrRd),
    .dataCtl    (dataCtl),
    .addrOut    (addrOut),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .instrWord  (instrWord),
    .readWord   (readWord)
  );

endmodule

// File: tb/bus_cycle_ctrl_tb_top.sv
`timescale 1ns/100ps
module bus_cycle_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ready = 1'b0;
  logic [31:0] rdData = '0;
  logic        loadIp = 1'b0;
  logic [31:0] newIp = '0;
  logic        execEn = 1'b0, execIo = 1'b0, execWr = 1'b0;
  logic [31:0] execAddr = '0, execWrData = '0;
  logic        busActive, memIoSel, wrRd, dataCtl, dataOe;
  logic [31:0] addrOut, dataOut, instrWord, readWord;

  always #2.5 clk = ~clk;

  bus_cycle_ctrl dut_i (
    .clk(clk), .rstN(rstN), .ready(ready), .rdData(rdData),
    .loadIp(loadIp), .newIp(newIp), .execEn(execEn), .execIo(execIo),
    .execWr(execWr), .execAddr(execAddr), .execWrData(execWrData),
    .busActive(busActive), .memIoSel(memIoSel), .wrRd(wrRd),
    .dataCtl(dataCtl), .addrOut(addrOut), .dataOut(dataOut),
    .dataOe(dataOe), .instrWord(instrWord), .readWord(readWord)
  );

  typedef struct packed {
    logic        en;
    logic        io;
    logic        wr;
    logic [3:0]  fWait;
    logic [3:0]  eWait;
    logic        ld;
    logic [31:0] nIp;
    logic [31:0] addr;
    logic [31:0] wdat;
    logic [31:0] rdat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 32'h0,         32'h0,        32'h0,         32'h0},
    '{1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 32'h0,         32'h0000_1000, 32'h0,        32'hA5A5_0001},
    '{1'b1, 1'b0, 1'b1, 4'd1, 4'd2, 1'b0, 32'h0,         32'h0000_2004, 32'hDEAD_BEEF, 32'h1111_1111},
    '{1'b1, 1'b1, 1'b0, 4'd0, 4'd1, 1'b0, 32'h0,         32'h0000_0060, 32'h0,        32'h1234_5678},
    '{1'b1, 1'b1, 1'b1, 4'd3, 4'd0, 1'b0, 32'h0,         32'h0000_0064, 32'h0000_00FF, 32'h2222_2222},
    '{1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 32'h8000_0000, 32'h0,        32'h0,         32'h0},
    '{1'b1, 1'b0, 1'b0, 4'd2, 4'd3, 1'b0, 32'h0,         32'hFFFF_FFF0, 32'h0,        32'h0BAD_F00D},
    '{1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 32'hFFFF_FFFC, 32'h0,        32'h0,         32'h0},
    '{1'b1, 1'b1, 1'b1, 4'd0, 4'd0, 1'b0, 32'h0,         32'h0000_0010, 32'hCAFE_0010, 32'h0},
    '{1'b0, 1'b0, 1'b0, 4'd1, 4'd0, 1'b0, 32'h0,         32'h0,        32'h0,         32'h0}
  };

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] expIp = '0;
  logic [31:0] lastRead = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] busBits();
    return {27'd0, busActive, memIoSel, wrRd, dataCtl, dataOe};
  endfunction

  task automatic runVec(input int idx);
    vec_t v = VECS[idx];
    logic [31:0] holdAddr;
    logic [31:0] expBits;
    string rq;
    // fetch phase
    chk("R2 fetch code", busBits(), 32'b11000);
    chk("R2 fetch addr", addrOut, expIp);
    ready = 1'b0;
    for (int w = 0; w < int'(v.fWait); w++) begin
      @(negedge clk);
      chk("R10 fetch held code", busBits(), 32'b11000);
      chk("R10 fetch held addr", addrOut, expIp);
    end
    rdData = 32'hC0DE_0000 | idx;
    ready = 1'b1;
    loadIp = v.ld;
    newIp = v.nIp;
    @(negedge clk);
    ready = 1'b0;
    loadIp = 1'b0;
    rdData = 32'h5555_AAAA;
    // decode cycle
    chk("R5 decode idle", busBits(), 32'b0);
    chk("R12 idle addr", addrOut, 32'h0);
    chk("R12 idle data", dataOut, 32'h0);
    chk("R3 instr captured", instrWord, 32'hC0DE_0000 | idx);
    expIp = v.ld ? v.nIp : expIp + 32'd4;
    execEn = v.en; execIo = v.io; execWr = v.wr;
    execAddr = v.addr; execWrData = v.wdat;
    @(negedge clk);
    execEn = 1'b0; execAddr = '0; execWrData = '0; execIo = 1'b0; execWr = 1'b0;
    if (v.en) begin
      rq = v.io ? (v.wr ? "R9" : "R8") : (v.wr ? "R7" : "R6");
      expBits = {27'd0, 1'b1, ~v.io, v.wr, 1'b1, v.wr};
      holdAddr = v.addr;
      chk({rq, " exec code"}, busBits(), expBits);
      chk({rq, " exec addr"}, addrOut, holdAddr);
      if (v.wr) chk({rq, " write data"}, dataOut, v.wdat);
      for (int w = 0; w < int'(v.eWait); w++) begin
        @(negedge clk);
        chk("R10 exec held code", busBits(), expBits);
        chk("R10 exec held addr", addrOut, holdAddr);
      end
      rdData = v.rdat;
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      if (!v.wr) lastRead = v.rdat;
      chk({rq, " readWord"}, readWord, lastRead);
    end else begin
      chk("R5 skip to fetch", busBits(), 32'b11000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset idle", busBits(), 32'b0);
    chk("R1 reset instr", instrWord, 32'h0);
    rstN = 1'b1;
    chk("R1 first cycle idle", busBits(), 32'b0);
    @(negedge clk);
    chk("R1 fetch after reset", busBits(), 32'b11000);
    for (int i = 0; i < NV; i++) runVec(i);
    // reset in the middle of a held execute cycle
    ready = 1'b1; rdData = 32'h1;
    @(negedge clk);
    ready = 1'b0;
    execEn = 1'b1; execIo = 1'b0; execWr = 1'b1; execAddr = 32'h40; execWrData = 32'h77;
    @(negedge clk);
    execEn = 1'b0;
    chk("R7 write before abort", busBits(), 32'b11111);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 abort idle", busBits(), 32'b0);
    chk("R11 abort oe", {31'd0, dataOe}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 restart fetch", busBits(), 32'b11000);
    chk("R1 restart addr", addrOut, 32'h0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule